// File: doc/BRIEF.md
# Sticky Transition Activity Monitor

This block watches two groups of design signals for a slow debug readout path. For every watched bit it keeps the latest sampled value and two sticky flags, one for a rising and one for a falling transition. A flag stays set once its edge has been seen, so a bit that toggles many times between two readouts is still reported as active, not just by its final level. Readouts are much rarer than design clock edges, so the flags are the only record of activity between them.

The first group is synchronous to the design clock. Its bits are edge-detected on design clock samples, and each bit also has a pair of edge-clocked capture cells that record any transition, including a pulse shorter than a clock period. The design-domain results are frozen into hold registers by a toggle request/acknowledge handshake whose control bits pass through two-flop synchronizers, so the readout side only copies data that has stopped changing. The second group is asynchronous: it is synchronized and edge-detected entirely in the readout clock domain. A one-cycle strobe in the readout domain starts a capture. The asynchronous results land on the next readout edge. The synchronous results land when the handshake completes, marked by a done pulse. Each capture clears the flags it reports.

Top module: `edge_activity_mon`

## Requirements
- R1: While reset is low and after it is released, all value, flag and done outputs are zero until activity is captured.
- R2: After a capture, bit i of `sv_rise` (`sv_fall`) is 1 exactly when bit i of `sync_in` went 0 to 1 (1 to 0) between two design clock samples since the previous capture, and bit i of `sv_val` is the settled value of `sync_in[i]`.
- R3: A bit that toggles several times between captures reports both its rising and its falling flag, and its value output shows its final level.
- R4: A capture clears the flags it reports, so a following capture with no activity in between reports all flags zero with unchanged values.
- R5: Every transition on a synchronous bit is reported in exactly one capture, whatever its timing relative to the clearing snapshot.
- R6: `sv_glitch[i]` is set by any transition of `sync_in[i]`, including a pulse shorter than a design clock period; such a pulse sets neither `sv_rise[i]` nor `sv_fall[i]` and leaves `sv_val[i]` unchanged.
- R7: Asynchronous bits are sampled only by `clk_rd`. An accepted strobe updates `av_val`, `av_rise` and `av_fall` on the readout edge that accepts it, covering every level that was held for at least three readout cycles before that edge.
- R8: `sv_done` is a single readout-cycle pulse after each accepted strobe, and the synchronous outputs change only in the cycle where it is high.
- R9: A strobe while a synchronous capture is still in flight is ignored: it produces no second done pulse and leaves the asynchronous outputs and flags untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dsn | input | 1 | Design clock; samples the synchronous group |
| clk_rd | input | 1 | Readout clock; samples the asynchronous group and runs the capture interface |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sync_in | input | SYNC_W | Signals synchronous to `clk_dsn` |
| async_in | input | ASYNC_W | Signals with no relation to either clock |
| rd_strobe | input | 1 | One readout-cycle request to capture and clear |
| sv_val | output | SYNC_W | Captured value of the synchronous group |
| sv_rise | output | SYNC_W | Captured rising-edge flags, synchronous group |
| sv_fall | output | SYNC_W | Captured falling-edge flags, synchronous group |
| sv_glitch | output | SYNC_W | Captured any-transition flags from the edge-clocked cells |
| sv_done | output | 1 | Pulses when the synchronous outputs have been refreshed |
| av_val | output | ASYNC_W | Captured value of the asynchronous group |
| av_rise | output | ASYNC_W | Captured rising-edge flags, asynchronous group |
| av_fall | output | ASYNC_W | Captured falling-edge flags, asynchronous group |

## Verification
The bench walks every ordered pair of 4-bit input words through both groups, so a swapped flag, an inverted edge or a stale value shows up as a mismatch on some transition. It moves one edge across sixteen design-clock offsets around the clearing snapshot and requires it in exactly one of two captures; a design that drops the same-cycle edge reports it nowhere, and one that keeps it in both reports it twice. It drives pulses shorter than a clock period and expects only the glitch flag, which catches a cell wired to the clocked detector, and it fires a second strobe mid-handshake, which a design without the busy guard turns into an extra done pulse and a cleared asynchronous flag.

// File: rtl/eam_pkg.sv
package eam_pkg;

    // A toggle request is outstanding while the two toggle bits differ.
    function automatic logic eam_pending(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/eam_glitch_cell.sv
module eam_glitch_cell (
    input  logic sig,
    input  logic clr,
    output logic hit
);
    logic up_q;
    logic dn_q;

    // Clocked by the monitored signal itself: catches edges of any width.
    always_ff @(posedge sig or posedge clr) begin
        if (clr) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    always_ff @(negedge sig or posedge clr) begin
        if (clr) dn_q <= 1'b0;
        else     dn_q <= 1'b1;
    end

    assign hit = up_q | dn_q;
endmodule

// File: rtl/eam_dsn_side.sv
module eam_dsn_side
    import eam_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sin,
    input  logic [W-1:0] gl_raw,
    input  logic         req_tgl,
    output logic [W-1:0] gl_clr,
    output logic         ack_tgl,
    output logic [W-1:0] hold_val,
    output logic [W-1:0] hold_rise,
    output logic [W-1:0] hold_fall,
    output logic [W-1:0] hold_gl
);
    typedef struct packed {
        logic [W-1:0] smp;
        logic [W-1:0] prv;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] gs1;
        logic [W-1:0] gs2;
        logic [W-1:0] gclr;
        logic [W-1:0] glit;
        logic [W-1:0] h_val;
        logic [W-1:0] h_rise;
        logic [W-1:0] h_fall;
        logic [W-1:0] h_gl;
        logic         rq1;
        logic         rq2;
        logic         ack;
    } dsn_st_t;

    dsn_st_t      st_d;
    dsn_st_t      st_q;
    logic [W-1:0] up_now;
    logic [W-1:0] dn_now;
    logic [W-1:0] gl_now;
    logic         snap;

    always_comb begin
        st_d   = st_q;
        st_d.smp = sin;
        st_d.prv = st_q.smp;
        up_now = st_q.smp & ~st_q.prv;
        dn_now = ~st_q.smp & st_q.prv;
        // glitch evidence: two-flop synchronize, then clear the cell
        st_d.gs1  = gl_raw;
        st_d.gs2  = st_q.gs1;
        st_d.gclr = st_q.gs2;
        gl_now    = st_q.gs2 & ~st_q.gclr;
        // capture request from the readout domain
        st_d.rq1 = req_tgl;
        st_d.rq2 = st_q.rq1;
        snap     = eam_pending(st_q.rq2, st_q.ack);
        if (snap) begin
            // freeze what was seen before this cycle; this cycle's edges
            // start the next collection window
            st_d.h_val  = st_q.prv;
            st_d.h_rise = st_q.rise;
            st_d.h_fall = st_q.fall;
            st_d.h_gl   = st_q.glit;
            st_d.rise   = up_now;
            st_d.fall   = dn_now;
            st_d.glit   = gl_now;
            st_d.ack    = st_q.rq2;
        end else begin
            st_d.rise = st_q.rise | up_now;
            st_d.fall = st_q.fall | dn_now;
            st_d.glit = st_q.glit | gl_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gl_clr    = st_q.gclr;
    assign ack_tgl   = st_q.ack;
    assign hold_val  = st_q.h_val;
    assign hold_rise = st_q.h_rise;
    assign hold_fall = st_q.h_fall;
    assign hold_gl   = st_q.h_gl;

    AST_SFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap) |-> (((st_q.rise & $past(st_q.rise)) == $past(st_q.rise)) &&
                          ((st_q.fall & $past(st_q.fall)) == $past(st_q.fall)) &&
                          ((st_q.glit & $past(st_q.glit)) == $past(st_q.glit)))); // R3

    AST_HOLD_ON_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap) |-> $stable({st_q.h_val, st_q.h_rise, st_q.h_fall, st_q.h_gl})); // R5
endmodule

// File: rtl/eam_rd_side.sv
module eam_rd_side
    import eam_pkg::*;
#(
    parameter int unsigned SW = 4,
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [AW-1:0] ain,
    input  logic          ack_tgl,
    input  logic [SW-1:0] h_val,
    input  logic [SW-1:0] h_rise,
    input  logic [SW-1:0] h_fall,
    input  logic [SW-1:0] h_gl,
    output logic          req_tgl,
    output logic [SW-1:0] sv_val,
    output logic [SW-1:0] sv_rise,
    output logic [SW-1:0] sv_fall,
    output logic [SW-1:0] sv_gl,
    output logic          sv_done,
    output logic [AW-1:0] av_val,
    output logic [AW-1:0] av_rise,
    output logic [AW-1:0] av_fall
);
    typedef struct packed {
        logic [AW-1:0] as1;
        logic [AW-1:0] as2;
        logic [AW-1:0] ap;
        logic [AW-1:0] ar;
        logic [AW-1:0] af;
        logic [AW-1:0] av_val;
        logic [AW-1:0] av_rise;
        logic [AW-1:0] av_fall;
        logic [SW-1:0] sv_val;
        logic [SW-1:0] sv_rise;
        logic [SW-1:0] sv_fall;
        logic [SW-1:0] sv_gl;
        logic          req;
        logic          ak1;
        logic          ak2;
        logic          seen;
        logic          done;
    } rd_st_t;

    rd_st_t        st_d;
    rd_st_t        st_q;
    logic [AW-1:0] a_up;
    logic [AW-1:0] a_dn;
    logic          busy;
    logic          acc;

    always_comb begin
        st_d = st_q;
        // asynchronous group: two-flop synchronizer plus a history stage
        st_d.as1 = ain;
        st_d.as2 = st_q.as1;
        st_d.ap  = st_q.as2;
        a_up = st_q.as2 & ~st_q.ap;
        a_dn = ~st_q.as2 & st_q.ap;
        busy = eam_pending(st_q.req, st_q.seen);
        acc  = strobe & ~busy;
        // acknowledge return path
        st_d.ak1  = ack_tgl;
        st_d.ak2  = st_q.ak1;
        st_d.done = 1'b0;
        if (eam_pending(st_q.ak2, st_q.seen)) begin
            st_d.seen    = st_q.ak2;
            st_d.done    = 1'b1;
            st_d.sv_val  = h_val;
            st_d.sv_rise = h_rise;
            st_d.sv_fall = h_fall;
            st_d.sv_gl   = h_gl;
        end
        if (acc) begin
            st_d.req     = ~st_q.req;
            st_d.av_val  = st_q.ap;
            st_d.av_rise = st_q.ar;
            st_d.av_fall = st_q.af;
            st_d.ar      = a_up;
            st_d.af      = a_dn;
        end else begin
            st_d.ar = st_q.ar | a_up;
            st_d.af = st_q.af | a_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl = st_q.req;
    assign sv_val  = st_q.sv_val;
    assign sv_rise = st_q.sv_rise;
    assign sv_fall = st_q.sv_fall;
    assign sv_gl   = st_q.sv_gl;
    assign sv_done = st_q.done;
    assign av_val  = st_q.av_val;
    assign av_rise = st_q.av_rise;
    assign av_fall = st_q.av_fall;

    AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(busy)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R8

    AST_SV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> $stable({st_q.sv_val, st_q.sv_rise, st_q.sv_fall, st_q.sv_gl})); // R8

    AST_AV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) |-> $stable({st_q.av_val, st_q.av_rise, st_q.av_fall})); // R9

    AST_AFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) |-> (((st_q.ar & $past(st_q.ar)) == $past(st_q.ar)) &&
                         ((st_q.af & $past(st_q.af)) == $past(st_q.af)))); // R3
endmodule

// File: rtl/edge_activity_mon.sv
module edge_activity_mon #(
    parameter int unsigned SYNC_W  = 4,
    parameter int unsigned ASYNC_W = 4
) (
    input  logic               clk_dsn,
    input  logic               clk_rd,
    input  logic               rst_n,
    input  logic [SYNC_W-1:0]  sync_in,
    input  logic [ASYNC_W-1:0] async_in,
    input  logic               rd_strobe,
    output logic [SYNC_W-1:0]  sv_val,
    output logic [SYNC_W-1:0]  sv_rise,
    output logic [SYNC_W-1:0]  sv_fall,
    output logic [SYNC_W-1:0]  sv_glitch,
    output logic               sv_done,
    output logic [ASYNC_W-1:0] av_val,
    output logic [ASYNC_W-1:0] av_rise,
    output logic [ASYNC_W-1:0] av_fall
);
    logic [SYNC_W-1:0] gl_raw;
    logic [SYNC_W-1:0] gl_clr;
    logic [SYNC_W-1:0] cell_clr;
    logic [SYNC_W-1:0] hold_val;
    logic [SYNC_W-1:0] hold_rise;
    logic [SYNC_W-1:0] hold_fall;
    logic [SYNC_W-1:0] hold_gl;
    logic              req_tgl;
    logic              ack_tgl;

    assign cell_clr = gl_clr | {SYNC_W{~rst_n}};

    for (genvar gi = 0; gi < SYNC_W; gi++) begin : g_cell
        eam_glitch_cell i_cell (
            .sig (sync_in[gi]),
            .clr (cell_clr[gi]),
            .hit (gl_raw[gi])
        );
    end

    eam_dsn_side #(.W(SYNC_W)) i_dsn (
        .clk       (clk_dsn),
        .rst_n     (rst_n),
        .sin       (sync_in),
        .gl_raw    (gl_raw),
        .req_tgl   (req_tgl),
        .gl_clr    (gl_clr),
        .ack_tgl   (ack_tgl),
        .hold_val  (hold_val),
        .hold_rise (hold_rise),
        .hold_fall (hold_fall),
        .hold_gl   (hold_gl)
    );

    eam_rd_side #(.SW(SYNC_W), .AW(ASYNC_W)) i_rd (
        .clk     (clk_rd),
        .rst_n   (rst_n),
        .strobe  (rd_strobe),
        .ain     (async_in),
        .ack_tgl (ack_tgl),
        .h_val   (hold_val),
        .h_rise  (hold_rise),
        .h_fall  (hold_fall),
        .h_gl    (hold_gl),
        .req_tgl (req_tgl),
        .sv_val  (sv_val),
        .sv_rise (sv_rise),
        .sv_fall (sv_fall),
        .sv_gl   (sv_glitch),
        .sv_done (sv_done),
        .av_val  (av_val),
        .av_rise (av_rise),
        .av_fall (av_fall)
    );
endmodule

// File: tb/test_edge_activity_mon.sv
`timescale 1ns/1ps
module test_edge_activity_mon;
    localparam int SW = 4;
    localparam int AW = 4;

    logic          clk_dsn = 1'b0;
    logic          clk_rd  = 1'b0;
    logic          rst_n   = 1'b0;
    logic [SW-1:0] sync_in  = '0;
    logic [AW-1:0] async_in = '0;
    logic          rd_strobe = 1'b0;
    logic [SW-1:0] sv_val, sv_rise, sv_fall, sv_glitch;
    logic          sv_done;
    logic [AW-1:0] av_val, av_rise, av_fall;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the expected results
    logic [SW-1:0] s_cur = '0, s_er = '0, s_ef = '0, s_eg = '0;
    logic [AW-1:0] a_cur = '0, a_er = '0, a_ef = '0;

    always #2 clk_dsn = ~clk_dsn;   // 250 MHz
    always #5 clk_rd  = ~clk_rd;

    edge_activity_mon #(.SYNC_W(SW), .ASYNC_W(AW)) i_edge_activity_mon (
        .clk_dsn(clk_dsn), .clk_rd(clk_rd), .rst_n(rst_n),
        .sync_in(sync_in), .async_in(async_in), .rd_strobe(rd_strobe),
        .sv_val(sv_val), .sv_rise(sv_rise), .sv_fall(sv_fall),
        .sv_glitch(sv_glitch), .sv_done(sv_done),
        .av_val(av_val), .av_rise(av_rise), .av_fall(av_fall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_sync(input logic [SW-1:0] v);
        @(negedge clk_dsn);
        s_er |= v & ~s_cur;
        s_ef |= s_cur & ~v;
        s_eg |= v ^ s_cur;
        s_cur = v;
        sync_in = v;
    endtask

    task automatic set_async(input logic [AW-1:0] v, input int hold);
        @(negedge clk_rd);
        a_er |= v & ~a_cur;
        a_ef |= a_cur & ~v;
        a_cur = v;
        async_in = v;
        repeat (hold) @(negedge clk_rd);
    endtask

    task automatic capture();
        bit seen;
        seen = 1'b0;
        @(negedge clk_rd) rd_strobe = 1'b1;
        @(negedge clk_rd) rd_strobe = 1'b0;
        repeat (40) begin
            if (!seen) begin
                @(negedge clk_rd);
                if (sv_done) seen = 1'b1;
            end
        end
        if (!seen) chk("R8 done after strobe", 0, 1);
    endtask

    task automatic check_sync(input string tag);
        chk({tag, " sv_val"},    int'(sv_val),    int'(s_cur));
        chk({tag, " sv_rise"},   int'(sv_rise),   int'(s_er));
        chk({tag, " sv_fall"},   int'(sv_fall),   int'(s_ef));
        chk({tag, " sv_glitch"}, int'(sv_glitch), int'(s_eg));
        s_er = '0; s_ef = '0; s_eg = '0;
    endtask

    task automatic check_async(input string tag);
        chk({tag, " av_val"},  int'(av_val),  int'(a_cur));
        chk({tag, " av_rise"}, int'(av_rise), int'(a_er));
        chk({tag, " av_fall"}, int'(av_fall), int'(a_ef));
        a_er = '0; a_ef = '0;
    endtask

    task automatic flush();
        repeat (6) @(negedge clk_dsn);
        capture();
        s_er = '0; s_ef = '0; s_eg = '0;
        a_er = '0; a_ef = '0;
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dones;
        logic r1, g1, r2, g2;
        logic [AW-1:0] a_old;

        // R1: reset state
        repeat (4) @(negedge clk_rd);
        chk("R1 sv_val in reset", int'(sv_val), 0);
        chk("R1 sv_done in reset", int'(sv_done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_rd);
        chk("R1 sv flags after reset", int'({sv_rise, sv_fall, sv_glitch}), 0);
        chk("R1 av outputs after reset", int'({av_val, av_rise, av_fall}), 0);

        // R2 / R7: every ordered pair of 4-bit words
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_sync(SW'(a));
                set_async(AW'(a), 4);
                flush();
                set_sync(SW'(b));
                set_async(AW'(b), 4);
                capture();
                check_sync("R2");
                check_async("R7");
            end
        end

        // R8: done is a single-cycle pulse
        @(negedge clk_rd);
        chk("R8 done low after pulse", int'(sv_done), 0);

        // R3: several toggles between captures
        set_sync(4'b0000);
        set_async(4'b0000, 4);
        flush();
        set_sync(4'b0010); set_sync(4'b0000); set_sync(4'b0010); set_sync(4'b0000);
        set_async(4'b0010, 1); set_async(4'b0000, 1);
        set_async(4'b0010, 1); set_async(4'b0000, 4);
        capture();
        check_sync("R3");
        check_async("R3");

        // R4: next capture with no activity is clean
        repeat (6) @(negedge clk_dsn);
        capture();
        check_sync("R4");
        check_async("R4");

        // R6: sub-cycle pulses, one high-going, one low-going
        set_sync(4'b1000);
        flush();
        @(posedge clk_dsn); #1 sync_in[2] = 1'b1; #1 sync_in[2] = 1'b0;
        @(posedge clk_dsn); #1 sync_in[3] = 1'b0; #1 sync_in[3] = 1'b1;
        s_eg = 4'b1100;
        repeat (6) @(negedge clk_dsn);
        capture();
        check_sync("R6");

        // R9: second strobe while the capture is in flight
        set_async(4'b0000, 4);
        flush();
        a_old = a_cur;
        @(negedge clk_rd);
        rd_strobe = 1'b1;
        async_in = 4'b0001;
        @(negedge clk_rd) rd_strobe = 1'b0;
        @(negedge clk_rd) rd_strobe = 1'b1;
        @(negedge clk_rd) rd_strobe = 1'b0;
        dones = (sv_done === 1'b1) ? 1 : 0;
        repeat (20) begin
            @(negedge clk_rd);
            if (sv_done === 1'b1) dones++;
        end
        chk("R9 single done pulse", dones, 1);
        chk("R9 av_val untouched by ignored strobe", int'(av_val), int'(a_old));
        a_cur = 4'b0001; a_er = 4'b0001; a_ef = '0;
        capture();
        check_async("R9");

        // R5: move one edge across the snapshot, expect it exactly once
        for (int d = 0; d < 16; d++) begin
            set_sync(s_cur & 4'b1110);
            flush();
            fork
                begin
                    capture();
                    r1 = sv_rise[0];
                    g1 = sv_glitch[0];
                end
                begin
                    repeat (d) @(negedge clk_dsn);
                    sync_in[0] = 1'b1;
                end
            join
            s_cur[0] = 1'b1;
            repeat (6) @(negedge clk_dsn);
            capture();
            r2 = sv_rise[0];
            g2 = sv_glitch[0];
            chk($sformatf("R5 rise once at offset %0d", d), int'(r1) + int'(r2), 1);
            chk($sformatf("R5 glitch once at offset %0d", d), int'(g1) + int'(g2), 1);
            chk($sformatf("R5 value at offset %0d", d), int'(sv_val[0]), 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule